// File: doc/BRIEF.md
# Maskable I2C Interrupt Controller

This block gathers the event sources of an I2C controller into one 12-bit raw status word. Ten of the sources are sticky event flags, set by single-cycle pulses from the bus engine and held until software clears them. The other two are level conditions, recomputed every cycle by comparing the receive and transmit queue fill levels against thresholds that software programs. A mask register selects which status bits may drive the single interrupt line. Software also sees a masked status view.

Clearing is a side effect of reading. Each clearable source has its own clear register, and reading that register clears only that source. Reading one combined register clears every event flag at once. The queues and the bus engine sit outside this block: it sees only their event pulses and fill counts. The register port is a plain one-cycle read/write strobe interface with no back-pressure. A read issued in one cycle returns its data in the next cycle.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset all event flags, the mask and both thresholds are 0, and `irq` is 0. With both fill levels at 0, the raw status therefore reads 0x010.
- R2: The status bit layout is: 0 RX underflow, 1 RX overflow, 2 RX at threshold, 3 TX overflow, 4 TX at or below threshold, 5 read request, 6 TX abort, 7 RX done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A pulse on `evt[b]` for a clearable bit b (every bit except 2 and 4) sets flag b, and the flag stays set until it is cleared. Reading address 0 returns the raw status.
- R3: `irq` is the OR of (raw status AND mask), where a mask bit of 1 enables that source. Address 2 holds the mask. Reading address 1 returns raw status AND mask.
- R4: Reading a per-source clear register clears only its own flag and returns that flag's value before the clear in bit 0. Addresses 6 to 15 map to status bits 0, 1, 3, 5, 6, 7, 8, 9, 10 and 11 in that order.
- R5: Reading address 5 returns the raw status and clears all ten event flags.
- R6: Bit 2 is 1 exactly when `rx_fill` is greater than the RX threshold at address 3. Programming N-1 therefore raises the bit at N entries.
- R7: Bit 4 is 1 exactly when `tx_fill` is less than or equal to the TX threshold at address 4.
- R8: Clear reads leave bits 2 and 4 unchanged, and pulses on `evt[2]` or `evt[4]` have no effect.
- R9: When an event pulse and a clear read of the same source fall in one cycle, the flag stays set.
- R10: Read data appears on `rdata` one cycle after the read strobe. The mask and both thresholds read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 12 | Write data |
| reg_rd | input | 1 | Read strobe (clears on clear addresses) |
| rdata | output | 12 | Read data, valid the cycle after `reg_rd` |
| evt | input | 12 | Event pulses, one per status bit |
| rx_fill | input | FILL_W | Receive queue fill level |
| tx_fill | input | FILL_W | Transmit queue fill level |
| irq | output | 1 | Interrupt line |

## Verification
The two functions that can fall in the same cycle are the setting of a flag by an event pulse and the clearing of that flag by a read. The bench drives `evt[9]` and a read of the stop-seen clear register on the same clock edge. It then reads the raw status and expects bit 9 to be set. It also checks a clear-all read taken while a level bit is active, and expects the level bit to survive the clear.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NSRC = 12;
  localparam int ADDR_W = 4;
  localparam int BIT_RXLVL = 2;
  localparam int BIT_TXLVL = 4;
  localparam logic [NSRC-1:0] CLR_MASK = ~((NSRC'(1) << BIT_RXLVL) | (NSRC'(1) << BIT_TXLVL));

  localparam logic [ADDR_W-1:0] A_RAW     = 4'd0;
  localparam logic [ADDR_W-1:0] A_MSKSTAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK    = 4'd2;
  localparam logic [ADDR_W-1:0] A_RXTHR   = 4'd3;
  localparam logic [ADDR_W-1:0] A_TXTHR   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CLRALL  = 4'd5;
  localparam int CLR_BASE = 6;

  // one-hot of the flag cleared by a per-source clear address (0 if none)
  function automatic logic [NSRC-1:0] clr_sel(input logic [ADDR_W-1:0] a);
    logic [NSRC-1:0] oh;
    int idx;
    oh = '0;
    idx = 0;
    for (int b = 0; b < NSRC; b++) begin
      if (CLR_MASK[b]) begin
        if (int'(a) == CLR_BASE + idx) oh[b] = 1'b1;
        idx++;
      end
    end
    return oh;
  endfunction
endpackage

// File: rtl/evt_flags.sv
module evt_flags
  import i2c_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] q_o
);
  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    if (CLR_MASK[b]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (!rst_n) q_o[b] <= 1'b0;
        else        q_o[b] <= set_i[b] | (q_o[b] & ~clr_i[b]);
      end
    end else begin : g_level
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/lvl_cmp.sv
module lvl_cmp #(
  parameter int FILL_W = 7,
  parameter int THR_W  = 12
) (
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic [THR_W-1:0]  rx_thr,
  input  logic [THR_W-1:0]  tx_thr,
  output logic              rx_hit,
  output logic              tx_hit
);
  localparam int CMP_W = (FILL_W > THR_W) ? FILL_W : THR_W;
  logic [CMP_W-1:0] rxf, txf, rxt, txt;
  always_comb begin
    rxf = CMP_W'(rx_fill);
    txf = CMP_W'(tx_fill);
    rxt = CMP_W'(rx_thr);
    txt = CMP_W'(tx_thr);
    rx_hit = rxf > rxt;
    tx_hit = txf <= txt;
  end
endmodule

// File: rtl/reg_port.sv
module reg_port
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NSRC-1:0]   reg_wdata,
  input  logic              reg_rd,
  input  logic [NSRC-1:0]   raw_i,
  input  logic [NSRC-1:0]   flags_i,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   rx_thr_o,
  output logic [NSRC-1:0]   tx_thr_o,
  output logic [NSRC-1:0]   clr_o,
  output logic [NSRC-1:0]   rdata
);
  logic [NSRC-1:0] sel_oh;
  logic [NSRC-1:0] rd_next;

  assign sel_oh = clr_sel(reg_addr);

  always_comb begin
    clr_o = '0;
    if (reg_rd) clr_o = (reg_addr == A_CLRALL) ? CLR_MASK : sel_oh;
  end

  always_comb begin
    case (reg_addr)
      A_RAW, A_CLRALL: rd_next = raw_i;
      A_MSKSTAT:       rd_next = raw_i & mask_o;
      A_MASK:          rd_next = mask_o;
      A_RXTHR:         rd_next = rx_thr_o;
      A_TXTHR:         rd_next = tx_thr_o;
      default:         rd_next = NSRC'(|(flags_i & sel_oh));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o   <= '0;
      rx_thr_o <= '0;
      tx_thr_o <= '0;
      rdata    <= '0;
    end else begin
      if (reg_wr) begin
        if (reg_addr == A_MASK)  mask_o   <= reg_wdata;
        if (reg_addr == A_RXTHR) rx_thr_o <= reg_wdata;
        if (reg_addr == A_TXTHR) tx_thr_o <= reg_wdata;
      end
      if (reg_rd) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int FILL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NSRC-1:0]   reg_wdata,
  input  logic              reg_rd,
  output logic [NSRC-1:0]   rdata,
  input  logic [NSRC-1:0]   evt,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  output logic              irq
);
  logic [NSRC-1:0] ev_q, clr_vec, raw_stat, mask_q, rx_thr_q, tx_thr_q;
  logic rx_hit, tx_hit;

  evt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt & CLR_MASK), .clr_i(clr_vec), .q_o(ev_q)
  );

  lvl_cmp #(.FILL_W(FILL_W), .THR_W(NSRC)) u_lvl (
    .rx_fill(rx_fill), .tx_fill(tx_fill), .rx_thr(rx_thr_q), .tx_thr(tx_thr_q),
    .rx_hit(rx_hit), .tx_hit(tx_hit)
  );

  always_comb begin
    raw_stat = ev_q;
    raw_stat[BIT_RXLVL] = rx_hit;
    raw_stat[BIT_TXLVL] = tx_hit;
  end

  reg_port u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .raw_i(raw_stat), .flags_i(ev_q),
    .mask_o(mask_q), .rx_thr_o(rx_thr_q), .tx_thr_o(tx_thr_q),
    .clr_o(clr_vec), .rdata(rdata)
  );

  assign irq = |(raw_stat & mask_q);
endmodule

// File: rtl/i2c_irq_chk.sv
module i2c_irq_chk
  import i2c_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic [NSRC-1:0]   rdata,
  input logic [NSRC-1:0]   evt,
  input logic [NSRC-1:0]   ev_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              irq
);
  // R2: with no read, no flag falls
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> ((ev_q & $past(ev_q)) == $past(ev_q)));
  // R9: a pulse always leaves its flag set, even against a clear
  p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & CLR_MASK) != '0) |=> ((ev_q & $past(evt & CLR_MASK)) == $past(evt & CLR_MASK)));
  // R5: clear-all with no pulse empties all flags
  p_clr_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CLRALL && (evt & CLR_MASK) == '0) |=> (ev_q == '0));
  // R3: nothing enabled, no interrupt
  p_masked_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  // R10: mask reads back one cycle later
  p_mask_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_MASK) |=> (rdata == $past(mask_q)));
endmodule

bind i2c_irq_ctrl i2c_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .rdata(rdata),
  .evt(evt), .ev_q(ev_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/tb_i2c_irq_ctrl.sv
module tb_i2c_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 7;

  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_wdata = 0, evt = 0, rdata;
  logic [FW-1:0] rx_fill = 0, tx_fill = 0;
  logic irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_ctrl #(.FILL_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .rdata(rdata), .evt(evt),
    .rx_fill(rx_fill), .tx_fill(tx_fill), .irq(irq)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%03h expected=0x%03h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [11:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = rdata;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  task automatic t_reset;
    logic [11:0] d;
    check("R1 irq", {11'b0, irq}, 12'h0);
    rd(0, d); check("R1 raw", d, 12'h010);
    rd(2, d); check("R1 mask", d, 12'h000);
    rd(3, d); check("R1 rxthr", d, 12'h000);
  endtask

  task automatic t_sticky;
    logic [11:0] d;
    pulse(12'h002);
    repeat (3) @(negedge clk);
    rd(0, d); check("R2 sticky", d, 12'h012);
    check("R3 irq masked off", {11'b0, irq}, 12'h0);
  endtask

  task automatic t_mask;
    logic [11:0] d;
    wr(2, 12'h002);
    check("R3 irq on", {11'b0, irq}, 12'h1);
    rd(1, d); check("R3 masked view", d, 12'h002);
    rd(2, d); check("R10 mask readback", d, 12'h002);
  endtask

  task automatic t_clr_one;
    logic [11:0] d;
    pulse(12'h041); // bits 0 and 6 added to bit 1
    rd(7, d); check("R4 clr returns old", d, 12'h001);
    rd(0, d); check("R4 only bit1 cleared", d, 12'h051);
    check("R4 irq dropped", {11'b0, irq}, 12'h0);
    rd(7, d); check("R4 clr returns zero", d, 12'h000);
  endtask

  task automatic t_clr_all;
    logic [11:0] d;
    pulse(12'h800);
    rd(5, d); check("R5 clear-all returns raw", d, 12'h851);
    rd(0, d); check("R5 all cleared", d, 12'h010);
  endtask

  task automatic t_rx_lvl;
    logic [11:0] d;
    wr(3, 12'd3); wr(2, 12'h004);
    @(negedge clk); rx_fill = 3;
    rd(0, d); check("R6 fill=thr", d, 12'h010);
    @(negedge clk); rx_fill = 4;
    rd(0, d); check("R6 fill>thr", d, 12'h014);
    check("R6 irq", {11'b0, irq}, 12'h1);
    rd(3, d); check("R10 rxthr readback", d, 12'd3);
  endtask

  task automatic t_tx_lvl;
    logic [11:0] d;
    wr(4, 12'd2);
    @(negedge clk); tx_fill = 2;
    rd(0, d); check("R7 fill=thr", d, 12'h014);
    @(negedge clk); tx_fill = 3;
    rd(0, d); check("R7 fill>thr", d, 12'h004);
    rd(4, d); check("R10 txthr readback", d, 12'd2);
  endtask

  task automatic t_levels_immune;
    logic [11:0] d;
    rd(5, d);
    rd(0, d); check("R8 level survives clear-all", d, 12'h004);
    @(negedge clk); rx_fill = 0;
    pulse(12'h014);
    rd(0, d); check("R8 pulses on level bits ignored", d, 12'h000);
  endtask

  task automatic t_collide;
    logic [11:0] d;
    @(negedge clk); evt = 12'h200; reg_addr = 13; reg_rd = 1;
    @(negedge clk); evt = 0; reg_rd = 0;
    rd(0, d); check("R9 event beats clear", d, 12'h200);
    rd(13, d); check("R9 later clear works", d, 12'h001);
    rd(0, d); check("R9 cleared", d, 12'h000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_sticky; t_mask; t_clr_one; t_clr_all;
        t_rx_lvl; t_tx_lvl; t_levels_immune; t_collide;
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0x000 expected=0x001");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule